// File: doc/BRIEF.md
# Five-Port Mesh Packet Router

This router sits at one node of a two-dimensional mesh of neural cores. It has five packet ports: one to the core attached to the node and one each towards the north, east, south and west neighbours. Every input and every output uses a valid/ready handshake. A packet moves only when both sides agree, so neighbouring routers need no fixed clock relationship beyond the synchronisers placed between them, and those are outside this block.

A 32-bit packet carries a kind bit (spike or debug), two signed relative offsets for X and Y, a redirect flag and a payload. The router corrects X before Y. Each hop moves the relevant offset one step towards zero, and a packet whose offsets are both zero leaves through the local port. A packet that has its redirect flag set and reaches its destination takes fresh offsets from the node's redirect setting, for example a core that performs partial summation. It is then routed again, once only. Each input holds up to two packets. Every output has a round-robin arbiter whose grant stays fixed until the chosen packet has been handed over, and a 5x5 crossbar carries each winner to its output.

Top module: `mesh_router`

## Requirements
- R1: Port indices are 0 local, 1 north, 2 east, 3 south, 4 west. A packet leaves east if its X offset is positive, west if negative. With X zero it leaves north if Y is positive, south if negative, and local when both are zero.
- R2: The packet word is kind [31] (0 spike, 1 debug), X offset [30:26] and Y offset [25:21] in two's complement, redirect flag [20] and payload [19:0]. On an east exit X decreases by 1, on a west exit X increases by 1, on a north exit Y decreases by 1 and on a south exit Y increases by 1. A local exit leaves both offsets unchanged.
- R3: A packet accepted with the redirect flag at 1 and both offsets at 0 has its offsets replaced by `redir_dx`/`redir_dy` as sampled at the accepting edge, and its flag cleared. It is then routed by R1 and R2. A flagged packet with a nonzero offset is routed normally and keeps its flag.
- R4: The kind bit and the payload pass through unchanged, and spike and debug packets are routed identically.
- R5: Each input stores up to two packets. `in_ready` of that input is low while two are held, and a packet offered while `in_ready` is low is not taken.
- R6: When several inputs hold packets for the same output, the output serves them in a rotating order. The search starts at the input after the one served last (after reset, input 0) and wraps from 4 to 0.
- R7: While an output is valid and not ready, its valid and data stay unchanged on the next cycle.
- R8: Packets from one input leave in the order they were accepted.
- R9: During and right after reset every output valid is low and every input ready is high.
- R10: A packet accepted at a rising edge by an input with an empty buffer, heading for an idle output, is presented on that output directly after the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_dx | input | 5 | X offset given to redirected packets (two's complement) |
| redir_dy | input | 5 | Y offset given to redirected packets (two's complement) |
| in_valid | input | 5 | Per-input packet valid, bit = port index |
| in_ready | output | 5 | Per-input space available |
| in_data | input | 160 | Input packets, port k at bits [32k+31:32k] |
| out_valid | output | 5 | Per-output packet valid |
| out_ready | input | 5 | Per-output downstream ready |
| out_data | output | 160 | Output packets, port k at bits [32k+31:32k] |

## Verification
A packet accepted at one rising edge is due on its output one nanosecond after that same edge, because only the input buffer stands between the ports. The bench drives inputs on the falling edge, waits for the accepting rising edge and samples 1 ns later. It then expects the handed-over packet to be gone after the next rising edge. Under contention each further winner appears one edge after the previous handover, so the round-robin checks step one edge at a time. A held output is compared again after several idle edges. The effect of a full buffer is checked on `in_ready` at the edge after the second acceptance, and again at the outputs once the output drains.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

    localparam int NPORT = 5;
    localparam int OFS_W = 5;
    localparam int PAY_W = 20;
    localparam int PKT_W = 2 + 2 * OFS_W + PAY_W;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    typedef struct packed {
        logic                    kind;
        logic signed [OFS_W-1:0] dx;
        logic signed [OFS_W-1:0] dy;
        logic                    redirect;
        logic [PAY_W-1:0]        payload;
    } pkt_t;

    // Swap in the node's redirect offsets once a flagged packet has arrived.
    function automatic pkt_t apply_redirect(pkt_t p,
                                            logic signed [OFS_W-1:0] rdx,
                                            logic signed [OFS_W-1:0] rdy);
        pkt_t r;
        r = p;
        if (p.redirect && p.dx == '0 && p.dy == '0) begin
            r.dx       = rdx;
            r.dy       = rdy;
            r.redirect = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/mr_route.sv
module mr_route
    import mesh_router_pkg::*;
(
    input  pkt_t  pkt_i,
    output port_e port_o,
    output pkt_t  pkt_o
);

    localparam logic signed [OFS_W-1:0] ZERO = '0;
    localparam logic signed [OFS_W-1:0] ONE  = OFS_W'(1);

    // Dimension order: X is corrected fully before Y is touched.
    always_comb begin
        pkt_o  = pkt_i;
        port_o = PORT_LOCAL;
        if (pkt_i.dx > ZERO) begin
            port_o   = PORT_EAST;
            pkt_o.dx = pkt_i.dx - ONE;
        end else if (pkt_i.dx < ZERO) begin
            port_o   = PORT_WEST;
            pkt_o.dx = pkt_i.dx + ONE;
        end else if (pkt_i.dy > ZERO) begin
            port_o   = PORT_NORTH;
            pkt_o.dy = pkt_i.dy - ONE;
        end else if (pkt_i.dy < ZERO) begin
            port_o   = PORT_SOUTH;
            pkt_o.dy = pkt_i.dy + ONE;
        end
    end

endmodule

// File: rtl/mr_in_buf.sv
module mr_in_buf
    import mesh_router_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid_i,
    output logic in_ready_o,
    input  pkt_t in_pkt_i,
    output logic head_valid_o,
    output pkt_t head_pkt_o,
    input  logic pop_i
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        pkt_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } buf_st_t;

    buf_st_t st_d, st_q;
    logic    push, pop;

    assign in_ready_o   = (st_q.cnt != CNT_W'(DEPTH));
    assign head_valid_o = (st_q.cnt != '0);
    assign head_pkt_o   = st_q.mem[st_q.rd];
    assign push         = in_valid_i && in_ready_o;
    assign pop          = pop_i && head_valid_o;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = in_pkt_i;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + PTR_W'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + PTR_W'(1);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mr_rr_arb.sv
module mr_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         out_ready_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic             lock;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] prio;
    } arb_st_t;

    arb_st_t          st_d, st_q;
    logic             found;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] sel;

    // Search starts at the requester after the last one served.
    always_comb begin
        int c;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            c = int'(st_q.prio) + k;
            if (c >= N) c = c - N;
            if (!found && req_i[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
    end

    always_comb begin
        st_d  = st_q;
        sel   = st_q.lock ? st_q.idx : pick;
        any_o = st_q.lock || found;
        for (int i = 0; i < N; i++) begin
            gnt_o[i] = any_o && (sel == IDX_W'(i));
        end
        if (any_o && out_ready_i) begin
            st_d.lock = 1'b0;
            st_d.prio = (sel == IDX_W'(N - 1)) ? '0 : sel + IDX_W'(1);
        end else if (any_o) begin
            st_d.lock = 1'b1;
            st_d.idx  = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int BUF_DEPTH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OFS_W-1:0]       redir_dx,
    input  logic [OFS_W-1:0]       redir_dy,
    input  logic [NPORT-1:0]       in_valid,
    output logic [NPORT-1:0]       in_ready,
    input  logic [NPORT*PKT_W-1:0] in_data,
    output logic [NPORT-1:0]       out_valid,
    input  logic [NPORT-1:0]       out_ready,
    output logic [NPORT*PKT_W-1:0] out_data
);

    pkt_t             in_fix   [NPORT];
    pkt_t             head_pkt [NPORT];
    pkt_t             fwd_pkt  [NPORT];
    port_e            fwd_port [NPORT];
    logic [NPORT-1:0] req_m    [NPORT];
    logic [NPORT-1:0] gnt_m    [NPORT];
    logic [NPORT-1:0] head_valid;
    logic [NPORT-1:0] pop;

    // Redirect is resolved on entry so a waiting packet never changes.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            in_fix[i] = apply_redirect(pkt_t'(in_data[i*PKT_W +: PKT_W]),
                                       $signed(redir_dx), $signed(redir_dy));
        end
    end

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        mr_in_buf #(.DEPTH(BUF_DEPTH)) u_buf (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_valid_i  (in_valid[gi]),
            .in_ready_o  (in_ready[gi]),
            .in_pkt_i    (in_fix[gi]),
            .head_valid_o(head_valid[gi]),
            .head_pkt_o  (head_pkt[gi]),
            .pop_i       (pop[gi])
        );
        mr_route u_route (
            .pkt_i (head_pkt[gi]),
            .port_o(fwd_port[gi]),
            .pkt_o (fwd_pkt[gi])
        );
    end

    always_comb begin
        for (int j = 0; j < NPORT; j++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_m[j][i] = head_valid[i] && (fwd_port[i] == 3'(j));
            end
        end
    end

    for (genvar gj = 0; gj < NPORT; gj++) begin : g_out
        mr_rr_arb #(.N(NPORT)) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (req_m[gj]),
            .out_ready_i(out_ready[gj]),
            .gnt_o      (gnt_m[gj]),
            .any_o      (out_valid[gj])
        );
    end

    // Crossbar and buffer release.
    always_comb begin
        out_data = '0;
        pop      = '0;
        for (int j = 0; j < NPORT; j++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_m[j][i]) begin
                    out_data[j*PKT_W +: PKT_W] = fwd_pkt[i];
                    pop[i] = pop[i] | out_ready[j];
                end
            end
        end
    end

endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk
    import mesh_router_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPORT-1:0]       out_valid,
    input logic [NPORT-1:0]       out_ready,
    input logic [NPORT*PKT_W-1:0] out_data
);

    localparam int DY_LSB  = PAY_W + 1;
    localparam int DX_LSB  = DY_LSB + OFS_W;
    localparam int RED_BIT = PAY_W;
    localparam int PL = 0;
    localparam int PN = 1;
    localparam int PE = 2;
    localparam int PS = 3;
    localparam int PW = 4;

    for (genvar gj = 0; gj < NPORT; gj++) begin : g_hold
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[gj] && !out_ready[gj]) |=>
            (out_valid[gj] && $stable(out_data[gj*PKT_W +: PKT_W])));
    end

    p_local_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PL] |-> (out_data[PL*PKT_W + DX_LSB +: OFS_W] == '0 &&
                           out_data[PL*PKT_W + DY_LSB +: OFS_W] == '0));

    p_east_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PE] |-> !out_data[PE*PKT_W + DX_LSB + OFS_W - 1]);

    p_west_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PW] |-> (out_data[PW*PKT_W + DX_LSB + OFS_W - 1] ||
                           out_data[PW*PKT_W + DX_LSB +: OFS_W] == '0));

    p_north_xdone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PN] |-> (out_data[PN*PKT_W + DX_LSB +: OFS_W] == '0));

    p_south_xdone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PS] |-> (out_data[PS*PKT_W + DX_LSB +: OFS_W] == '0));

    p_redirect_spent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PL] |-> !out_data[PL*PKT_W + RED_BIT]);

endmodule

bind mesh_router mesh_router_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/test_mesh_router.sv
`timescale 1ns/1ps
module test_mesh_router;
    import mesh_router_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [OFS_W-1:0]       redir_dx, redir_dy;
    logic [NPORT-1:0]       in_valid, in_ready, out_valid, out_ready;
    logic [NPORT*PKT_W-1:0] in_data, out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mesh_router i_mesh_router (
        .clk(clk), .rst_n(rst_n), .redir_dx(redir_dx), .redir_dy(redir_dy),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic pkt_t mk(logic kind, int dx, int dy, logic ind, int pay);
        pkt_t p;
        p.kind     = kind;
        p.dx       = OFS_W'(dx);
        p.dy       = OFS_W'(dy);
        p.redirect = ind;
        p.payload  = PAY_W'(pay);
        return p;
    endfunction

    // Reference: redirect at destination, then X before Y, one step per hop.
    function automatic void model(input pkt_t p, input int rdx, input int rdy,
                                  output int port, output pkt_t q);
        int x, y;
        q = p;
        x = int'(p.dx);
        y = int'(p.dy);
        if (p.redirect && x == 0 && y == 0) begin
            x = rdx; y = rdy; q.redirect = 1'b0;
        end
        if (x > 0)      begin port = 2; x = x - 1; end
        else if (x < 0) begin port = 4; x = x + 1; end
        else if (y > 0) begin port = 1; y = y - 1; end
        else if (y < 0) begin port = 3; y = y + 1; end
        else            port = 0;
        q.dx = OFS_W'(x);
        q.dy = OFS_W'(y);
    endfunction

    function automatic logic [PKT_W-1:0] out_pkt(int j);
        return out_data[j*PKT_W +: PKT_W];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        in_valid  = '0;
        out_ready = '1;
        in_data   = '0;
        redir_dx  = '0;
        redir_dy  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_check(input int i, input pkt_t p, input int rdx, input int rdy,
                              input string tag);
        int   port;
        pkt_t q;
        @(negedge clk);
        redir_dx = OFS_W'(rdx);
        redir_dy = OFS_W'(rdy);
        in_data[i*PKT_W +: PKT_W] = p;
        in_valid    = '0;
        in_valid[i] = 1'b1;
        @(posedge clk); #1;
        in_valid = '0;
        model(p, rdx, rdy, port, q);
        check({tag, " port"}, 32'(out_valid), 32'(1 << port));
        check({tag, " data"}, out_pkt(port), q);
        @(posedge clk); #1;
        check({tag, " drained"}, 32'(out_valid), 32'd0);
    endtask

    task automatic rr_round(input logic [NPORT-1:0] who, input int o0, input int o1, input int o2,
                            input string tag);
        int order[3];
        order[0] = o0; order[1] = o1; order[2] = o2;
        @(negedge clk);
        for (int i = 0; i < NPORT; i++) in_data[i*PKT_W +: PKT_W] = mk(1'b0, 2, 0, 1'b0, i);
        in_valid = who;
        @(posedge clk); #1;
        in_valid = '0;
        for (int k = 0; k < 3; k++) begin
            check({tag, " valid"}, 32'(out_valid), 32'h4);
            check({tag, " winner"}, 32'(out_pkt(2)), 32'(mk(1'b0, 1, 0, 1'b0, order[k])));
            @(posedge clk); #1;
        end
        check({tag, " empty"}, 32'(out_valid), 32'd0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R9 reset state
        check("R9 out_valid", 32'(out_valid), 32'd0);
        check("R9 in_ready", 32'(in_ready), 32'h1f);

        // Directed corner cases
        send_check(2, mk(1'b0, 0, 0, 1'b0, 'h5), 0, 0, "R1 local");
        send_check(1, mk(1'b1, 0, 0, 1'b1, 'h12345), 2, -1, "R3 redirect east");
        send_check(0, mk(1'b0, 0, 0, 1'b1, 'h00abc), 0, 0, "R3 redirect local");
        send_check(3, mk(1'b0, -2, 0, 1'b1, 'h777), 1, 1, "R3 not arrived keeps flag");
        send_check(4, mk(1'b0, 0, -15, 1'b0, 'hfffff), 0, 0, "R2 south edge");

        // Constrained random single packets through an idle router
        for (int it = 0; it < 80; it++) begin
            pkt_t p;
            int   ip, rx, ry;
            ip = int'($urandom_range(0, 4));
            rx = int'($urandom_range(0, 6)) - 3;
            ry = int'($urandom_range(0, 6)) - 3;
            p  = mk(1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 30)) - 15,
                    int'($urandom_range(0, 30)) - 15,
                    1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 1048575)));
            if ($urandom_range(0, 3) == 0) begin p.dx = '0; p.dy = '0; end
            send_check(ip, p, rx, ry, "R1/R2/R4/R10 random");
        end

        // R6 rotating order, from a known pointer after reset
        do_reset();
        rr_round(5'b01011, 0, 1, 3, "R6 first round");
        rr_round(5'b10011, 4, 0, 1, "R6 wrap round");

        // R5 buffer depth, R7 hold, R8 order
        @(negedge clk);
        out_ready = 5'b11011;
        in_data[0 +: PKT_W] = mk(1'b0, 3, 0, 1'b0, 'hA);
        in_valid = 5'b00001;
        @(posedge clk); #1;
        in_valid = '0;
        check("R5 one held ready", 32'(in_ready[0]), 32'd1);
        check("R10 held output valid", 32'(out_valid), 32'h4);
        @(negedge clk);
        in_data[0 +: PKT_W] = mk(1'b1, 1, 0, 1'b0, 'hB);
        in_valid = 5'b00001;
        @(posedge clk); #1;
        in_valid = '0;
        check("R5 full ready low", 32'(in_ready[0]), 32'd0);
        @(negedge clk);
        in_data[0 +: PKT_W] = mk(1'b0, 1, 0, 1'b0, 'hC);
        in_valid = 5'b00001;
        @(posedge clk); #1;
        in_valid = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R7 held data", 32'(out_pkt(2)), 32'(mk(1'b0, 2, 0, 1'b0, 'hA)));
        check("R7 held valid", 32'(out_valid), 32'h4);
        @(negedge clk);
        out_ready = '1;
        @(posedge clk); #1;
        check("R8 second in order", 32'(out_pkt(2)), 32'(mk(1'b1, 0, 0, 1'b0, 'hB)));
        check("R5 space again", 32'(in_ready[0]), 32'd1);
        @(posedge clk); #1;
        check("R5 refused packet absent", 32'(out_valid), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule